// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the address-generation half of a microprogrammed control unit. It holds the control-address register, which addresses an external control-memory ROM, and a control register that captures the microinstruction the ROM returns. Each microinstruction is horizontal. One group of bits drives the control lines directly. The rest of the word tells the sequencer where to go next: a condition selector, a branch kind and a target address.

Every microinstruction takes two clock cycles. In the fetch phase the word at the current control address is captured into the control register. In the execute phase the control lines are driven from the captured word. At the end of the execute phase the next control address is loaded. It is chosen from four sources: the incremented address, the target field, the opcode-mapped routine start, or the single return register that a call fills.

The state machine has two states. ST_FETCH always moves to ST_EXEC, capturing the word. ST_EXEC always moves to ST_FETCH, loading the next address. Reset enters ST_FETCH.

Top module: `useq_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the control address is 0, the block is in the fetch phase (ctrl_valid = 0, ctrl = 0) and the return register holds 0.
- R2: The phases alternate, fetch then execute, starting with fetch. mem_word is captured at the end of the fetch cycle. The control address holds its value through the execute cycle and changes only at the end of it.
- R3: The word layout is: target address in bits [6:0], branch kind in [8:7], condition selector in [10:9] and control field in [18:11]. During execute, ctrl equals the captured control field bit for bit, whatever mem_word does in that cycle. During fetch, ctrl is 0.
- R4: Condition selector value 0 is always true. Values 1, 2 and 3 select status bits 0, 1 and 2. status and opcode are sampled at the clock edge that ends the execute phase.
- R5: Branch kind 00 is a jump. When the condition is true the next address is the target field; otherwise it is the current address plus one.
- R6: Branch kind 01 is a call. When the condition is true, the return register receives the current address plus one and the next address is the target field. When the condition is false the next address is the current address plus one and the return register is unchanged.
- R7: Branch kind 10 is a return. The next address is the return register, whatever the condition.
- R8: Branch kind 11 is a dispatch. The next address is a 0 bit, then the 4-bit opcode, then two 0 bits (opcode times 4), whatever the condition.
- R9: Incrementing address 127 gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_word | input | 19 | Microinstruction read from control memory at `car` |
| status | input | 3 | Status bits for the condition selector |
| opcode | input | 4 | Machine-instruction opcode used by dispatch |
| car | output | 7 | Control address driven to control memory |
| ctrl | output | 8 | Control lines from the captured microinstruction |
| ctrl_valid | output | 1 | High in the execute phase |

## Verification
The embedded properties assume three things about the environment. mem_word is the word stored at `car` during the fetch cycle. status and opcode are settled before the edge that ends execute. Reset is held for at least one clock. The bench meets these by changing every input only on the falling clock edge. During fetch it presents the modelled memory word. It changes status, opcode and mem_word again after each sample, so that only the values at the sampling edges can affect the result. Random words cover every branch kind and every condition selector. Directed steps add the address wrap, a call whose condition is false, and a return straight after reset.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        BT_JUMP = 2'b00,
        BT_CALL = 2'b01,
        BT_RET  = 2'b10,
        BT_MAP  = 2'b11
    } btype_e;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } phase_e;

endpackage

// File: rtl/useq_cond.sv
module useq_cond #(
    parameter int NSTAT = 3,
    parameter int SELW  = 2
) (
    input  logic [NSTAT-1:0] status,
    input  logic [SELW-1:0]  sel,
    output logic             cond_ok
);
    localparam int NC = 1 << SELW;

    logic [NC-1:0] cand;

    // Entry 0 is the always-true condition (R4)
    assign cand[0] = 1'b1;

    for (genvar i = 1; i < NC; i++) begin : g_cand
        if (i <= NSTAT) begin : g_live
            assign cand[i] = status[i-1];
        end else begin : g_pad
            assign cand[i] = 1'b0;
        end
    end

    assign cond_ok = cand[sel];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW        = 7,
    parameter int OPW       = 4,
    parameter int SLOT_BITS = 2
) (
    input  logic [AW-1:0]  car,
    input  logic [AW-1:0]  ret_addr,
    input  logic [AW-1:0]  target,
    input  btype_e         btype,
    input  logic           cond_ok,
    input  logic [OPW-1:0] opcode,
    output logic [AW-1:0]  nxt,
    output logic           push
);
    localparam int PADW = AW - OPW - SLOT_BITS;

    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;

    assign inc_addr = car + AW'(1);   // wraps at the top (R9)
    assign map_addr = {{PADW{1'b0}}, opcode, {SLOT_BITS{1'b0}}};

    always_comb begin
        push = 1'b0;
        unique case (btype)
            BT_JUMP: nxt = cond_ok ? target : inc_addr;
            BT_CALL: begin
                nxt  = cond_ok ? target : inc_addr;
                push = cond_ok;
            end
            BT_RET:  nxt = ret_addr;
            BT_MAP:  nxt = map_addr;
            default: nxt = inc_addr;
        endcase
    end

endmodule

// File: rtl/useq_retreg.sv
module useq_retreg #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (push)
            dout <= din;
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int AW    = 7,
    parameter int CW    = 8,
    parameter int SELW  = 2,
    parameter int NSTAT = 3,
    parameter int OPW   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW+SELW+2+AW-1:0]    mem_word,
    input  logic [NSTAT-1:0]           status,
    input  logic [OPW-1:0]             opcode,
    output logic [AW-1:0]              car,
    output logic [CW-1:0]              ctrl,
    output logic                       ctrl_valid
);
    localparam int UW      = CW + SELW + 2 + AW;
    localparam int ADDR_LO = 0;
    localparam int BT_LO   = AW;
    localparam int SEL_LO  = AW + 2;
    localparam int CTRL_LO = AW + 2 + SELW;

    phase_e        phase;
    logic [UW-1:0] cr;
    logic [AW-1:0] nxt;
    logic [AW-1:0] ret_addr;
    logic          push;
    logic          cond_ok;
    btype_e        btype;
    logic          in_exec;

    assign btype   = btype_e'(cr[BT_LO +: 2]);
    assign in_exec = (phase == ST_EXEC);

    useq_cond #(.NSTAT(NSTAT), .SELW(SELW)) u_cond (
        .status  (status),
        .sel     (cr[SEL_LO +: SELW]),
        .cond_ok (cond_ok)
    );

    useq_next #(.AW(AW), .OPW(OPW), .SLOT_BITS(2)) u_next (
        .car      (car),
        .ret_addr (ret_addr),
        .target   (cr[ADDR_LO +: AW]),
        .btype    (btype),
        .cond_ok  (cond_ok),
        .opcode   (opcode),
        .nxt      (nxt),
        .push     (push)
    );

    useq_retreg #(.AW(AW)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push && in_exec),
        .din   (car + AW'(1)),
        .dout  (ret_addr)
    );

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_FETCH;
        end else begin
            unique case (phase)
                ST_FETCH: phase <= ST_EXEC;
                ST_EXEC:  phase <= ST_FETCH;
            endcase
        end
    end

    // Address and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car <= '0;
            cr  <= '0;
        end else begin
            unique case (phase)
                ST_FETCH: cr  <= mem_word;
                ST_EXEC:  car <= nxt;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ctrl_valid = 1'b0;
        ctrl       = '0;
        unique case (phase)
            ST_FETCH: ;
            ST_EXEC: begin
                ctrl_valid = 1'b1;
                ctrl       = cr[CTRL_LO +: CW];
            end
        endcase
    end

    // R1: first cycle out of reset starts fetching at address zero
    a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (car == '0 && !ctrl_valid));

    // R2: phases alternate
    a_r2_fetch_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |=> ctrl_valid);
    a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |=> !ctrl_valid);

    // R2: address stays put across the fetch capture
    a_r2_car_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |=> $stable(car));

    // R5: a taken jump lands on the target field
    a_r5_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && btype == BT_JUMP && cond_ok) |=> car == $past(cr[ADDR_LO +: AW]));

    // R6: a taken call stores the address after the caller
    a_r6_call_save: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && btype == BT_CALL && cond_ok) |=> ret_addr == $past(car) + AW'(1));

    // R7: a return resumes at the saved address
    a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && btype == BT_RET) |=> car == $past(ret_addr));

    // R8: dispatch lands on a four-slot routine boundary in the lower half
    a_r8_map_align: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && btype == BT_MAP) |=> (car[1:0] == 2'b00 && car[AW-1] == 1'b0));

endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] mem_word = '0;
    logic [2:0]  status = '0;
    logic [3:0]  opcode = '0;
    logic [6:0]  car;
    logic [7:0]  ctrl;
    logic        ctrl_valid;

    int tests = 0;
    int fails = 0;
    logic [6:0] exp_car = '0;
    logic [6:0] exp_sbr = '0;

    useq_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_word   (mem_word),
        .status     (status),
        .opcode     (opcode),
        .car        (car),
        .ctrl       (ctrl),
        .ctrl_valid (ctrl_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R2: run hung, got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [18:0] mk(input logic [7:0] c, input logic [1:0] sel,
                                       input logic [1:0] bt, input logic [6:0] a);
        return {c, sel, bt, a};
    endfunction

    // Reference next-address model from R4..R9
    task automatic model(input logic [18:0] w, input logic [2:0] s, input logic [3:0] o);
        logic [1:0] sel;
        logic       ok;
        sel = w[10:9];
        ok  = (sel == 2'd0) ? 1'b1 : s[sel - 2'd1];
        case (w[8:7])
            2'b00: exp_car = ok ? w[6:0] : exp_car + 7'd1;
            2'b01: begin
                if (ok) begin
                    exp_sbr = exp_car + 7'd1;
                    exp_car = w[6:0];
                end else begin
                    exp_car = exp_car + 7'd1;
                end
            end
            2'b10: exp_car = exp_sbr;
            default: exp_car = {1'b0, o, 2'b00};
        endcase
    endtask

    // One microinstruction: starts and ends at a falling edge in fetch phase
    task automatic step(input logic [18:0] w, input logic [2:0] s, input logic [3:0] o, input string tag);
        chk(ctrl_valid == 1'b0, "R2 fetch phase", ctrl_valid, 0);
        chk(ctrl == 8'h00, "R3 idle lines in fetch", ctrl, 0);
        mem_word = w;
        @(negedge clk);
        mem_word = 19'($urandom);
        status   = s;
        opcode   = o;
        #1;
        chk(ctrl_valid == 1'b1, "R2 execute phase", ctrl_valid, 1);
        chk(ctrl == w[18:11], "R3 control field", ctrl, w[18:11]);
        chk(car == exp_car, "R2 address held in execute", car, exp_car);
        model(w, s, o);
        @(negedge clk);
        status = 3'($urandom);
        opcode = 4'($urandom);
        chk(car == exp_car, tag, car, exp_car);
    endtask

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        chk(car == 7'd0, "R1 reset address", car, 0);
        chk(ctrl_valid == 1'b0, "R1 reset phase", ctrl_valid, 0);
        rst_n = 1'b1;
        chk(car == 7'd0, "R1 address after release", car, 0);

        step(mk(8'hA5, 2'd0, 2'b00, 7'h7F), 3'b000, 4'h0, "R5 unconditional jump");
        step(mk(8'h3C, 2'd1, 2'b00, 7'h55), 3'b110, 4'h0, "R9 increment wraps 127 to 0");
        step(mk(8'h01, 2'd0, 2'b01, 7'h20), 3'b000, 4'h0, "R6 taken call");
        step(mk(8'h80, 2'd0, 2'b11, 7'h05), 3'b000, 4'hA, "R8 dispatch opcode A");
        step(mk(8'hFF, 2'd2, 2'b01, 7'h66), 3'b101, 4'h0, "R6 call not taken");
        step(mk(8'h00, 2'd1, 2'b10, 7'h44), 3'b000, 4'h0, "R7 return ignores false condition");
        step(mk(8'h5A, 2'd3, 2'b00, 7'h33), 3'b100, 4'h0, "R4 selector 3 uses status bit 2");
        step(mk(8'h12, 2'd2, 2'b00, 7'h11), 3'b010, 4'h0, "R4 selector 2 uses status bit 1");
        step(mk(8'h34, 2'd1, 2'b11, 7'h22), 3'b000, 4'hF, "R8 dispatch ignores condition");
        step(mk(8'h56, 2'd3, 2'b00, 7'h70), 3'b011, 4'h0, "R4 selector 3 false goes sequential");

        for (int i = 0; i < NRAND; i++) begin
            logic [18:0] w;
            string tg;
            w = 19'($urandom);
            case (w[8:7])
                2'b00: tg = "R5 random jump";
                2'b01: tg = "R6 random call";
                2'b10: tg = "R7 random return";
                default: tg = "R8 random dispatch";
            endcase
            step(w, 3'($urandom), 4'($urandom), tg);
        end

        // Reset again mid-run: the return register must clear too
        rst_n = 1'b0;
        @(negedge clk);
        chk(car == 7'd0, "R1 mid-run reset address", car, 0);
        chk(ctrl_valid == 1'b0, "R1 mid-run reset phase", ctrl_valid, 0);
        rst_n = 1'b1;
        exp_car = '0;
        exp_sbr = '0;
        step(mk(8'h99, 2'd0, 2'b00, 7'h40), 3'b000, 4'h0, "R5 jump after reset");
        step(mk(8'h77, 2'd0, 2'b10, 7'h40), 3'b000, 4'h0, "R1 return register cleared");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule